// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 93 pins. The pins are grouped into 32-bit banks: pin n belongs to bank n/32 at bit n%32. For each pin, software sets an output-enable and an input-enable bit, the output value, and pull-up, pull-down and open-drain bits. The controller only stores the pull and open-drain bits and passes them to the pad ring. The block samples pin levels through a two-flop synchronizer, and software can read them back.

Each pin has its own interrupt detector. A mode bit selects edge detection or level detection. In edge mode, rising and falling edges each have a disable bit: clearing the bit arms that edge. In level mode, a polarity bit picks the active level and a level-mask bit suppresses the detector. Detected events latch into a status register that software clears by writing ones. A per-pin mask gates status onto one registered interrupt line. A global hold bit forces that line low while software services it.

The register interface uses word addresses. Address bits [5:2] pick a register group and bits [1:0] pick the bank. Reads return data one cycle after the read strobe.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Word address bits [5:2] give the group and bits [1:0] the bank. Group codes: 0 output-enable, 1 input-enable, 2 output data, 3 pin input, 4 pull-up, 5 pull-down, 6 open-drain, 7 mode, 8 rise-disable, 9 fall-disable, 10 level-low, 11 level-mask, 12 status, 13 irq-mask, 14 global. A write to a configuration group is returned by a later read of the same address, and read data appears on the cycle after the read strobe.
- R2: Bits at or above pin 93 (bits 31..29 of bank 2) and every bit of bank 3 read as zero, and writes to them have no effect.
- R3: After reset, rise-disable, fall-disable, level-mask and irq-mask read all ones on implemented bits. Every other register reads zero, read data is zero and the interrupt line is low.
- R4: A pin drives its output-data bit, and its output enable is high only when its output-enable bit is 1 and its input-enable bit is 0.
- R5: The pull-up, pull-down and open-drain bits appear unchanged on the matching pin-level outputs.
- R6: The pin input group returns each pin's level after two synchronizing flops, and writes to it have no effect.
- R7: In edge mode (mode bit 0), a rising edge sets the pin's status bit when its rise-disable bit is 0, and a falling edge does so when its fall-disable bit is 0. The status bit is set on the third clock edge after the pin changes.
- R8: An edge whose disable bit is 1 leaves the status bit clear.
- R9: In level mode (mode bit 1), the status bit is set on every cycle in which the pin is at the active level (low when level-low is 1, high when it is 0) and level-mask is 0. While the pin stays active, clearing the bit does not keep it clear. With level-mask at 1 the detector is silent.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A detection in the same cycle wins over the clear.
- R11: The interrupt line is a register that goes high one edge after any status bit with a 0 in irq-mask. It is held low while bit 16 of the global register (bank 0) is 1. That bit reads back at position 16.
- R12: Read data changes only on a cycle with the read strobe asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address: group in [5:2], bank in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 93 | Pin levels from the pads |
| pin_out | output | 93 | Output value per pin |
| pin_oe | output | 93 | Output enable per pin |
| pin_pu | output | 93 | Pull-up request per pin |
| pin_pd | output | 93 | Pull-down request per pin |
| pin_od | output | 93 | Open-drain request per pin |
| irq | output | 1 | Aggregated interrupt, registered |

## Verification
Counting from a pin change applied between edges, the synchronized level is readable after the second edge, the status bit sets on the third edge and the interrupt line rises on the fourth. Read data is due one edge after the read strobe, and the pin-control outputs follow a register write on the write edge itself. The bench samples every output at the falling edge. Most checks wait a margin of several cycles past the due edge. One test counts edges exactly after a rising edge, expecting the interrupt still low after three edges and high after four, so any added or missing register stage is reported.

// File: rtl/gpio_bank_pkg.sv
// Shared constants, register-group codes and helper functions for the
// banked GPIO controller. Assumes at most four banks (two bank-select bits).
package gpio_bank_pkg;
    localparam int WORD_W   = 32;
    localparam int GRP_W    = 4;
    localparam int BSEL_W   = 2;
    localparam int NUM_GRP  = 2 ** GRP_W;
    localparam int HOLD_BIT = 16;

    typedef enum logic [GRP_W-1:0] {
        GRP_OUT_EN   = 4'd0,
        GRP_IN_EN    = 4'd1,
        GRP_DOUT     = 4'd2,
        GRP_DIN      = 4'd3,
        GRP_PULL_UP  = 4'd4,
        GRP_PULL_DN  = 4'd5,
        GRP_OPEN_DR  = 4'd6,
        GRP_MODE     = 4'd7,
        GRP_RISE_OFF = 4'd8,
        GRP_FALL_OFF = 4'd9,
        GRP_LVL_LOW  = 4'd10,
        GRP_LVL_MASK = 4'd11,
        GRP_STATUS   = 4'd12,
        GRP_IRQ_MASK = 4'd13,
        GRP_GLOBAL   = 4'd14,
        GRP_RSVD     = 4'd15
    } grp_e;

    // Mask of the bits of one bank that map to an existing pin.
    function automatic logic [WORD_W-1:0] live_bits(input int bank, input int npins);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (bank * WORD_W + i < npins) m[i] = 1'b1;
        end
        return m;
    endfunction

    // True for groups held as plain per-bank configuration words.
    function automatic logic grp_is_cfg(input grp_e g);
        return !(g == GRP_DIN || g == GRP_STATUS || g == GRP_GLOBAL || g == GRP_RSVD);
    endfunction

    // True for configuration groups that come out of reset as all ones.
    function automatic logic grp_resets_high(input grp_e g);
        return (g == GRP_RISE_OFF) || (g == GRP_FALL_OFF) ||
               (g == GRP_LVL_MASK) || (g == GRP_IRQ_MASK);
    endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer for the asynchronous pin inputs.
// Assumes each bit is sampled independently; no bus coherency is implied.
module gpio_pin_sync #(
    parameter int W = 93
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the pin levels through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
// Configuration storage for the banked GPIO controller: one word per
// group and bank for every plain configuration group, plus the global
// interrupt hold bit. Bits with no pin behind them stay zero.
// Assumes the caller decodes address into group and bank.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS  = 93,
    parameter int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  grp_e                                 wr_grp,
    input  logic [BSEL_W-1:0]                    wr_bank,
    input  logic [WORD_W-1:0]                    wr_data,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]     cfg_q [NUM_GRP],
    output logic                                 hold_q
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam logic [WORD_W-1:0] LIVE = live_bits(b, NUM_PINS);
            if (grp_is_cfg(grp_e'(g))) begin : g_store
                localparam logic [WORD_W-1:0] RST_VAL =
                    grp_resets_high(grp_e'(g)) ? LIVE : '0;
                logic [WORD_W-1:0] word_q;

                // Load this word on a matching write, keeping dead bits zero.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        word_q <= RST_VAL;
                    else if (wr_en && wr_grp == grp_e'(g) && wr_bank == BSEL_W'(b))
                        word_q <= wr_data & LIVE;
                end
                assign cfg_q[g][b] = word_q;
            end else begin : g_none
                assign cfg_q[g][b] = '0;
            end
        end
    end

    // Global register: only the interrupt hold bit of bank 0 is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (wr_en && wr_grp == GRP_GLOBAL && wr_bank == '0)
            hold_q <= wr_data[HOLD_BIT];
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// Interrupt detection and status for one 32-pin bank. Edge mode compares
// the synchronized level with its previous value; level mode watches the
// level against a per-pin polarity. Status bits are sticky and cleared by
// writing ones; a detection in the same cycle wins over the clear.
// Assumes 'lvl' is already synchronized to clk.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter logic [WORD_W-1:0] LIVE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] lvl,
    input  logic [WORD_W-1:0] mode,
    input  logic [WORD_W-1:0] rise_off,
    input  logic [WORD_W-1:0] fall_off,
    input  logic [WORD_W-1:0] lvl_low,
    input  logic [WORD_W-1:0] lvl_mask,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] clr_data,
    output logic [WORD_W-1:0] status
);
    logic [WORD_W-1:0] prev;
    logic [WORD_W-1:0] rise_hit;
    logic [WORD_W-1:0] fall_hit;
    logic [WORD_W-1:0] level_hit;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] clr_vec;

    // Form the per-pin detection and clear vectors.
    always_comb begin
        rise_hit  = ~mode & ~rise_off & lvl & ~prev;
        fall_hit  = ~mode & ~fall_off & ~lvl & prev;
        level_hit = mode & ~lvl_mask & (lvl ^ lvl_low);
        set_vec   = (rise_hit | fall_hit | level_hit) & LIVE;
        clr_vec   = clr_en ? clr_data : '0;
    end

    // Remember the last level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // Update sticky status: clear by write-one, set by detection.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // R10: a written one clears the bit unless a detection coincides.
    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((status & $past(clr_data & ~set_vec)) == '0));

    // R10: a bit not written with one never drops.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr_vec)) == $past(status & ~clr_vec)));

    for (genvar i = 0; i < WORD_W; i++) begin : g_chk
        if (LIVE[i]) begin : g_live
            // R7: an armed rising edge latches status.
            a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(lvl[i]) && !mode[i] && !rise_off[i]) |=> status[i]);
            // R7: an armed falling edge latches status.
            a_r7_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(lvl[i]) && !mode[i] && !fall_off[i]) |=> status[i]);
            // R9: an unmasked active level keeps status set.
            a_r9_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (mode[i] && !lvl_mask[i] && (lvl[i] != lvl_low[i])) |=> status[i]);
        end else begin : g_dead
            // R2: bits without a pin never report.
            a_r2_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> !status[i]);
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Top of the banked GPIO controller. Decodes the word address into group
// and bank, hosts configuration storage, the pin synchronizer and one
// interrupt unit per bank, drives the pin-control vectors, the registered
// read data and the registered aggregated interrupt.
// Assumes single-cycle write and read strobes from the host side.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 93
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [GRP_W+BSEL_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    input  logic [NUM_PINS-1:0]       pin_in,
    output logic [NUM_PINS-1:0]       pin_out,
    output logic [NUM_PINS-1:0]       pin_oe,
    output logic [NUM_PINS-1:0]       pin_pu,
    output logic [NUM_PINS-1:0]       pin_pd,
    output logic [NUM_PINS-1:0]       pin_od,
    output logic                      irq
);
    localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

    grp_e                             a_grp;
    logic [BSEL_W-1:0]                a_bank;
    logic [NUM_BANKS-1:0][WORD_W-1:0] cfg_q [NUM_GRP];
    logic                             hold_q;
    logic [NUM_PINS-1:0]              pin_s;
    logic [NUM_BANKS-1:0][WORD_W-1:0] lvl_w;
    logic [NUM_BANKS-1:0][WORD_W-1:0] status_w;
    logic [WORD_W-1:0]                rd_word;

    assign a_grp  = grp_e'(bus_addr[GRP_W+BSEL_W-1:BSEL_W]);
    assign a_bank = bus_addr[BSEL_W-1:0];

    gpio_cfg_regs #(
        .NUM_PINS  (NUM_PINS),
        .NUM_BANKS (NUM_BANKS)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_grp  (a_grp),
        .wr_bank (a_bank),
        .wr_data (bus_wdata),
        .cfg_q   (cfg_q),
        .hold_q  (hold_q)
    );

    gpio_pin_sync #(
        .W (NUM_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            if (b * WORD_W + i < NUM_PINS) begin : g_pin
                localparam int N = b * WORD_W + i;
                assign lvl_w[b][i] = pin_s[N];
                assign pin_out[N]  = cfg_q[GRP_DOUT][b][i];
                assign pin_oe[N]   = cfg_q[GRP_OUT_EN][b][i] & ~cfg_q[GRP_IN_EN][b][i];
                assign pin_pu[N]   = cfg_q[GRP_PULL_UP][b][i];
                assign pin_pd[N]   = cfg_q[GRP_PULL_DN][b][i];
                assign pin_od[N]   = cfg_q[GRP_OPEN_DR][b][i];
            end else begin : g_nopin
                assign lvl_w[b][i] = 1'b0;
            end
        end

        gpio_irq_bank #(
            .LIVE (live_bits(b, NUM_PINS))
        ) u_irq (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (lvl_w[b]),
            .mode     (cfg_q[GRP_MODE][b]),
            .rise_off (cfg_q[GRP_RISE_OFF][b]),
            .fall_off (cfg_q[GRP_FALL_OFF][b]),
            .lvl_low  (cfg_q[GRP_LVL_LOW][b]),
            .lvl_mask (cfg_q[GRP_LVL_MASK][b]),
            .clr_en   (bus_wr && a_grp == GRP_STATUS && a_bank == BSEL_W'(b)),
            .clr_data (bus_wdata),
            .status   (status_w[b])
        );
    end

    // Select the word addressed for a read.
    always_comb begin
        rd_word = '0;
        if (int'(a_bank) < NUM_BANKS) begin
            case (a_grp)
                GRP_DIN:    rd_word = lvl_w[a_bank];
                GRP_STATUS: rd_word = status_w[a_bank];
                GRP_GLOBAL: rd_word = (a_bank == '0) ? (WORD_W'(hold_q) << HOLD_BIT) : '0;
                default:    rd_word = cfg_q[a_grp][a_bank];
            endcase
        end
    end

    // Capture read data only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    // Register the aggregated, unmasked, non-held interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (|(status_w & ~cfg_q[GRP_IRQ_MASK])) & ~hold_q;
    end

    // R11: the hold bit keeps the line low on the following cycle.
    a_r11_hold_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> !irq);

    // R12: read data is steady without a read strobe.
    a_r12_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R4: an input-enabled pin never has its driver on.
    a_r4_input_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_oe[0] & cfg_q[GRP_IN_EN][0][0]) == 1'b0));
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
    localparam int NP = 93;
    localparam logic [3:0] G_OE  = 4'd0,  G_IE  = 4'd1,  G_DO  = 4'd2,  G_DI  = 4'd3;
    localparam logic [3:0] G_PU  = 4'd4,  G_PD  = 4'd5,  G_OD  = 4'd6,  G_MD  = 4'd7;
    localparam logic [3:0] G_RO  = 4'd8,  G_FO  = 4'd9,  G_LL  = 4'd10, G_LM  = 4'd11;
    localparam logic [3:0] G_ST  = 4'd12, G_IM  = 4'd13, G_GL  = 4'd14;
    localparam int NV = 22;

    // {read, group, bank, data, expected, requirement}
    localparam logic [74:0] VEC [NV] = '{
        {1'b0, G_OE, 2'd0, 32'hA5A50F0F, 32'h0,        4'd1},
        {1'b1, G_OE, 2'd0, 32'h0,        32'hA5A50F0F, 4'd1},  // R1
        {1'b0, G_DO, 2'd1, 32'h12345678, 32'h0,        4'd1},
        {1'b1, G_DO, 2'd1, 32'h0,        32'h12345678, 4'd1},  // R1
        {1'b0, G_PU, 2'd2, 32'hFFFFFFFF, 32'h0,        4'd2},
        {1'b1, G_PU, 2'd2, 32'h0,        32'h1FFFFFFF, 4'd2},  // R2
        {1'b0, G_MD, 2'd3, 32'hFFFFFFFF, 32'h0,        4'd2},
        {1'b1, G_MD, 2'd3, 32'h0,        32'h0,        4'd2},  // R2
        {1'b0, G_DI, 2'd0, 32'hFFFFFFFF, 32'h0,        4'd6},
        {1'b1, G_DI, 2'd0, 32'h0,        32'h0,        4'd6},  // R6
        {1'b1, G_RO, 2'd2, 32'h0,        32'h1FFFFFFF, 4'd3},  // R3
        {1'b1, G_IM, 2'd0, 32'h0,        32'hFFFFFFFF, 4'd3},  // R3
        {1'b1, G_LM, 2'd1, 32'h0,        32'hFFFFFFFF, 4'd3},  // R3
        {1'b1, G_FO, 2'd0, 32'h0,        32'hFFFFFFFF, 4'd3},  // R3
        {1'b1, G_ST, 2'd0, 32'h0,        32'h0,        4'd3},  // R3
        {1'b0, G_GL, 2'd0, 32'hFFFFFFFF, 32'h0,        4'd11},
        {1'b1, G_GL, 2'd0, 32'h0,        32'h00010000, 4'd11}, // R11
        {1'b0, G_GL, 2'd0, 32'h0,        32'h0,        4'd11},
        {1'b1, G_GL, 2'd0, 32'h0,        32'h0,        4'd11}, // R11
        {1'b0, G_OE, 2'd0, 32'h0,        32'h0,        4'd1},
        {1'b0, G_DO, 2'd1, 32'h0,        32'h0,        4'd1},
        {1'b0, G_PU, 2'd2, 32'h0,        32'h0,        4'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_pu, pin_pd, pin_od;
    logic          irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .pin_pd(pin_pd), .pin_od(pin_od), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] g, input logic [1:0] b, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {g, b}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] g, input logic [1:0] b, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = {g, b};
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        idle(3);
        // R3: reset state at the ports
        check("R3 rdata", bus_rdata, 32'h0);
        check("R3 irq", {31'b0, irq}, 32'h0);
        check("R3 oe", pin_oe[31:0], 32'h0);
        check("R3 out", pin_out[31:0], 32'h0);
        rst_n = 1'b1;
        idle(1);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][74]) begin
                rd(VEC[i][73:70], VEC[i][69:68], v);
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][35:4]);
            end else begin
                wr(VEC[i][73:70], VEC[i][69:68], VEC[i][67:36]);
            end
        end

        // R4: direction and output value
        wr(G_OE, 2'd0, 32'h000000FF);
        wr(G_IE, 2'd0, 32'h0000000F);
        wr(G_DO, 2'd0, 32'h000000AA);
        check("R4 oe low bank", pin_oe[31:0], 32'h000000F0);
        check("R4 out low bank", pin_out[31:0], 32'h000000AA);
        wr(G_OE, 2'd2, 32'h10000000);
        check("R4 oe pin92", {31'b0, pin_oe[92]}, 32'h1);
        wr(G_OE, 2'd0, 32'h0);
        wr(G_IE, 2'd0, 32'h0);

        // R5: pad attribute export
        wr(G_PD, 2'd1, 32'h00000F00);
        check("R5 pull-down", pin_pd[63:32], 32'h00000F00);
        wr(G_OD, 2'd2, 32'h10000001);
        check("R5 open-drain", {3'b0, pin_od[92:64]}, 32'h10000001);
        wr(G_PU, 2'd0, 32'h80000001);
        check("R5 pull-up", pin_pu[31:0], 32'h80000001);

        // R6: synchronized input readback
        @(negedge clk);
        pin_in[40] = 1'b1; pin_in[92] = 1'b1;
        idle(4);
        rd(G_DI, 2'd1, v);
        check("R6 din bank1", v, 32'h00000100);
        rd(G_DI, 2'd2, v);
        check("R6 din bank2", v, 32'h10000000);

        // R7: rising edge on pin 0, exact interrupt timing
        wr(G_RO, 2'd0, 32'hFFFFFFFE);
        wr(G_FO, 2'd0, 32'hFFFFFFFD);
        wr(G_IM, 2'd0, 32'hFFFFFFFE);
        @(negedge clk);
        pin_in[0] = 1'b1;
        idle(3);
        check("R7 irq not before 4th edge", {31'b0, irq}, 32'h0);
        idle(1);
        check("R7 irq at 4th edge", {31'b0, irq}, 32'h1);
        rd(G_ST, 2'd0, v);
        check("R7 rise status", v, 32'h1);
        // R10: writing zero keeps the bit
        wr(G_ST, 2'd0, 32'h0);
        rd(G_ST, 2'd0, v);
        check("R10 zero write", v, 32'h1);
        held = v;
        // R10 and R12: clear, rdata steady without a read
        wr(G_ST, 2'd0, 32'h1);
        idle(2);
        check("R12 rdata steady", bus_rdata, held);
        check("R11 irq drops after clear", {31'b0, irq}, 32'h0);
        rd(G_ST, 2'd0, v);
        check("R10 w1c", v, 32'h0);

        // R8: disabled edges; R7: falling edge on pin 1
        @(negedge clk);
        pin_in[1] = 1'b1;
        idle(5);
        rd(G_ST, 2'd0, v);
        check("R8 rise disabled pin1", v, 32'h0);
        @(negedge clk);
        pin_in[0] = 1'b0;
        idle(5);
        rd(G_ST, 2'd0, v);
        check("R8 fall disabled pin0", v, 32'h0);
        @(negedge clk);
        pin_in[1] = 1'b0;
        idle(5);
        rd(G_ST, 2'd0, v);
        check("R7 fall status", v, 32'h2);
        wr(G_ST, 2'd0, 32'h2);

        // R9: level detection on pin 33 (bank 1 bit 1)
        wr(G_MD, 2'd1, 32'h00000002);
        wr(G_LL, 2'd1, 32'h0);
        wr(G_LM, 2'd1, 32'hFFFFFFFD);
        idle(4);
        rd(G_ST, 2'd1, v);
        check("R9 inactive level", v, 32'h0);
        @(negedge clk);
        pin_in[33] = 1'b1;
        idle(5);
        rd(G_ST, 2'd1, v);
        check("R9 high level", v, 32'h2);
        wr(G_ST, 2'd1, 32'h2);
        rd(G_ST, 2'd1, v);
        check("R9 level persists over clear", v, 32'h2);
        @(negedge clk);
        pin_in[33] = 1'b0;
        idle(5);
        wr(G_ST, 2'd1, 32'h2);
        rd(G_ST, 2'd1, v);
        check("R9 cleared when inactive", v, 32'h0);
        wr(G_LL, 2'd1, 32'h00000002);
        idle(4);
        rd(G_ST, 2'd1, v);
        check("R9 low level", v, 32'h2);

        // R11: aggregation, hold and mask
        wr(G_IM, 2'd1, 32'hFFFFFFFD);
        idle(3);
        check("R11 unmasked irq", {31'b0, irq}, 32'h1);
        wr(G_GL, 2'd0, 32'h00010000);
        idle(2);
        check("R11 hold", {31'b0, irq}, 32'h0);
        wr(G_GL, 2'd0, 32'h0);
        idle(2);
        check("R11 release", {31'b0, irq}, 32'h1);
        wr(G_IM, 2'd1, 32'hFFFFFFFF);
        idle(2);
        check("R11 masked", {31'b0, irq}, 32'h0);

        // R9: level mask silences the detector
        wr(G_LM, 2'd1, 32'hFFFFFFFF);
        wr(G_ST, 2'd1, 32'h2);
        idle(4);
        rd(G_ST, 2'd1, v);
        check("R9 level masked", v, 32'h0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule